// File: doc/BRIEF.md
# Overlapped Parallel Sample Framer with Quarter-Rate Carrier Mixer

This block sits at the front of a parallel demodulator. On each parallel clock it takes one group of `LANES` new ADC samples (16 by default). It joins that group with the group accepted before it, which gives a frame of `2*LANES` samples. Each frame overlaps the one before it by half, so every sample appears in two frames: once in the upper half and once in the lower half. The next stage, a frequency-domain transform, needs this overlap.

Every sample in the frame is then multiplied by a replica of the sampled intermediate-frequency carrier. The carrier runs at one quarter of the sample rate, so its replica repeats +1, 0, -1, 0. The multiply therefore reduces to passing the sample, zeroing it, or negating it.

The carrier phase follows the absolute index of each accepted sample, so it stays continuous from frame to frame. It also stays continuous across cycles in which no group arrives. With 4 samples per symbol, each group of 16 advances the stream by 4 symbols. One frame goes out with a valid flag for each accepted group. The first group after reset gives no valid frame, because its overlap half is still empty.

Top module: `overlap_frame_mixer`

## Requirements
- R1: While reset is held and in the cycle after it, `frm_vld` is 0 and `frm_data` is all zeros.
- R2: The first group accepted after reset (`smp_vld` = 1) produces no valid frame: `frm_vld` stays 0 in the following cycle.
- R3: Every accepted group after the first one raises `frm_vld` in the next cycle. The output is registered, so the latency is exactly one cycle.
- R4: Frame lane k, at bits [k*9 +: 9], holds these samples:
  - for k < LANES, sample k of the previous accepted group;
  - for k >= LANES, sample k-LANES of the current group.
  
  Input sample j sits at bits [j*8 +: 8], and sample 0 is the oldest.
- R5: Number the accepted samples from 0 starting at reset. A sample with index n is multiplied by +1, 0, -1, 0 when n mod 4 is 0, 1, 2, 3 respectively.
- R6: Samples are 8-bit two's complement and mixed outputs are 9-bit two's complement with no saturation. Negating -128 gives +128.
- R7: A cycle with `smp_vld` = 0 is ignored. In the next cycle `frm_vld` is 0 and `frm_data` is unchanged. The overlap contents and the carrier phase do not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | A new sample group is present on `smp_data` |
| smp_data | input | LANES*SW (128) | New samples, sample 0 oldest, in the low bits |
| frm_vld | output | 1 | `frm_data` holds a new complete frame |
| frm_data | output | 2*LANES*OW (288) | Mixed frame: previous group in the low half, current group in the high half |

## Verification
The hardest situation to reach is a group that arrives after one or more idle cycles. In that case the overlap half and the carrier phase must come from the last accepted group, not from the idle cycle. The stimulus places random stall cycles between random sample groups. A reference model advances its own sample index and previous-group copy only on accepted groups, so any slip in overlap or phase shows up in the next frame. Directed frames of all -128, all +127 and all zero cover the widening corner and the zero lanes of the carrier.

// File: rtl/ofm_pkg.sv
// Package: shared carrier phase encoding for the overlapped framer.
// Assumes a carrier at one quarter of the sample rate, so four phases suffice.
package ofm_pkg;
    typedef enum logic [1:0] {
        PH_POS  = 2'd0,   // replica +1
        PH_ZUP  = 2'd1,   // replica 0
        PH_NEG  = 2'd2,   // replica -1
        PH_ZDN  = 2'd3    // replica 0
    } carrier_ph_e;
endpackage

// File: rtl/ofm_capture.sv
// Module: ofm_capture
// Holds the most recent accepted sample group, which becomes the overlap
// half of the next frame, and a flag that says the overlap half is filled.
// Assumes smp_vld marks exactly the cycles whose group is to be accepted.
module ofm_capture #(
    parameter int LANES = 16,
    parameter int SW    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_vld,
    input  logic [LANES*SW-1:0]   smp_data,
    output logic [LANES*SW-1:0]   hold_data,
    output logic                  primed
);
    // Purpose: keep the last accepted group and note that one has arrived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            primed    <= 1'b0;
        end else if (smp_vld) begin
            hold_data <= smp_data;
            primed    <= 1'b1;
        end
    end
endmodule

// File: rtl/ofm_phase.sv
// Module: ofm_phase
// Tracks the carrier phase of the next incoming sample and gives the phase
// of the oldest sample in the frame being formed (the overlap half).
// Assumes the phase period is 4 samples; the step per group is LANES mod 4.
module ofm_phase #(
    parameter int LANES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_vld,
    output logic [1:0] frame_base
);
    localparam logic [1:0] STEP = 2'(LANES % 4);

    logic [1:0] next_ph;

    // Purpose: advance the phase of the next sample only on accepted groups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_ph <= 2'd0;
        end else if (smp_vld) begin
            next_ph <= next_ph + STEP;
        end
    end

    // Purpose: the overlap half started LANES samples before the current group.
    always_comb begin
        frame_base = next_ph - STEP;
    end
endmodule

// File: rtl/ofm_mixer.sv
// Module: ofm_mixer
// Multiplies each frame lane by the quarter-rate carrier replica. Lane k
// uses phase (base + k) mod 4. The output is widened by one bit, so the
// negation of the most negative input cannot overflow.
module ofm_mixer #(
    parameter int NLANE = 32,
    parameter int SW    = 8,
    parameter int OW    = SW + 1
) (
    input  logic [1:0]           base,
    input  logic [NLANE*SW-1:0]  frame_in,
    output logic [NLANE*OW-1:0]  frame_out
);
    import ofm_pkg::*;

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        logic [SW-1:0]    raw;
        logic [OW-1:0]    ext;
        carrier_ph_e      ph;

        // Purpose: sign-extend the lane sample and find its carrier phase.
        always_comb begin
            raw = frame_in[k*SW +: SW];
            ext = {{(OW-SW){raw[SW-1]}}, raw};
            ph  = carrier_ph_e'(base + 2'(k % 4));
        end

        // Purpose: apply +1, 0, -1 or 0 according to the phase.
        always_comb begin
            case (ph)
                PH_POS:  frame_out[k*OW +: OW] = ext;
                PH_NEG:  frame_out[k*OW +: OW] = -ext;
                default: frame_out[k*OW +: OW] = '0;
            endcase
        end
    end
endmodule

// File: rtl/overlap_frame_mixer.sv
// Module: overlap_frame_mixer (top)
// Builds a frame of 2*LANES samples from the previous and current accepted
// groups, carrier-mixes it, and registers it with a valid flag. The first
// frame after reset is suppressed. Idle cycles leave all state unchanged.
// Assumes the synchronous active-low reset is held for at least one edge.
module overlap_frame_mixer #(
    parameter int LANES = 16,
    parameter int SW    = 8,
    parameter int OW    = SW + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      smp_vld,
    input  logic [LANES*SW-1:0]       smp_data,
    output logic                      frm_vld,
    output logic [2*LANES*OW-1:0]     frm_data
);
    localparam int NLANE = 2 * LANES;

    logic [LANES*SW-1:0]  hold_data;
    logic                 primed;
    logic [1:0]           frame_base;
    logic [NLANE*SW-1:0]  frame_raw;
    logic [NLANE*OW-1:0]  frame_mix;

    ofm_capture #(.LANES(LANES), .SW(SW)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_vld   (smp_vld),
        .smp_data  (smp_data),
        .hold_data (hold_data),
        .primed    (primed)
    );

    ofm_phase #(.LANES(LANES)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_vld    (smp_vld),
        .frame_base (frame_base)
    );

    // Purpose: older group in the low lanes, newer group in the high lanes.
    always_comb begin
        frame_raw = {smp_data, hold_data};
    end

    ofm_mixer #(.NLANE(NLANE), .SW(SW), .OW(OW)) u_mixer (
        .base      (frame_base),
        .frame_in  (frame_raw),
        .frame_out (frame_mix)
    );

    // Purpose: register the mixed frame and flag it once the overlap is filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_vld  <= 1'b0;
            frm_data <= '0;
        end else begin
            frm_vld <= smp_vld && primed;
            if (smp_vld) begin
                frm_data <= frame_mix;
            end
        end
    end
endmodule

// File: rtl/ofm_checker.sv
// Module: ofm_checker
// Protocol and overlap properties for overlap_frame_mixer, bound to the top.
// Keeps its own count of accepted groups, saturating at two.
module ofm_checker #(
    parameter int LANES = 16,
    parameter int OW    = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_vld,
    input  logic                   frm_vld,
    input  logic [2*LANES*OW-1:0]  frm_data
);
    localparam int HALF = LANES * OW;

    logic [1:0] acc_cnt;

    // Purpose: count accepted groups since reset, stopping at two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt <= 2'd0;
        end else if (smp_vld && acc_cnt != 2'd2) begin
            acc_cnt <= acc_cnt + 2'd1;
        end
    end

    // R2: no valid frame until two groups have been accepted
    assert_first_suppressed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |-> acc_cnt == 2'd2);

    // R3: an accepted group with a filled overlap gives a frame next cycle
    assert_frame_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && acc_cnt != 2'd0) |=> frm_vld);

    // R7: idle cycles give no frame and leave the data unchanged
    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> (!frm_vld && $stable(frm_data)));

    // R4: with a phase step of zero, the new low half repeats the last high half
    if (LANES % 4 == 0) begin : g_overlap
        assert_overlap_reuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (frm_vld && $past(frm_vld)) |-> frm_data[HALF-1:0] == $past(frm_data[2*HALF-1:HALF]));
    end
endmodule

bind overlap_frame_mixer ofm_checker #(.LANES(LANES), .OW(OW)) u_ofm_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .frm_vld  (frm_vld),
    .frm_data (frm_data)
);

// File: tb/test_overlap_frame_mixer.sv
module test_overlap_frame_mixer;
    localparam int LANES = 16;
    localparam int SW    = 8;
    localparam int OW    = 9;
    localparam int NL    = 2 * LANES;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   smp_vld = 1'b0;
    logic [LANES*SW-1:0]    smp_data = '0;
    logic                   frm_vld;
    logic [NL*OW-1:0]       frm_data;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state
    logic [LANES*SW-1:0] ref_prev = '0;
    int                  ref_idx = 0;
    bit                  ref_primed = 1'b0;
    logic [NL*OW-1:0]    ref_data = '0;
    logic                ref_vld = 1'b0;

    overlap_frame_mixer #(.LANES(LANES), .SW(SW), .OW(OW)) i_overlap_frame_mixer (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .smp_data (smp_data),
        .frm_vld  (frm_vld),
        .frm_data (frm_data)
    );

    always #10 clk = ~clk;

    // carrier replica at quarter rate: +1, 0, -1, 0 by index mod 4 (R5, R6)
    function automatic logic [OW-1:0] mix_one(input logic [SW-1:0] s, input int idx);
        int ph = ((idx % 4) + 4) % 4;
        int v  = $signed(s);
        if (ph == 0) return OW'(v);
        if (ph == 2) return OW'(-v);
        return '0;
    endfunction

    function automatic logic [NL*OW-1:0] ref_frame(input logic [LANES*SW-1:0] prev,
                                                   input logic [LANES*SW-1:0] cur,
                                                   input int idx);
        logic [NL*OW-1:0] f;
        for (int k = 0; k < LANES; k++) begin
            f[k*OW +: OW]         = mix_one(prev[k*SW +: SW], idx - LANES + k);
            f[(k+LANES)*OW +: OW] = mix_one(cur[k*SW +: SW], idx + k);
        end
        return f;
    endfunction

    task automatic check(input bit ok, input string req, input logic [NL*OW-1:0] act,
                         input logic [NL*OW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, then check at the next falling edge
    task automatic step(input logic v, input logic [LANES*SW-1:0] d, input string tag);
        smp_vld  = v;
        smp_data = d;
        if (v) begin
            ref_data   = ref_frame(ref_prev, d, ref_idx);
            ref_vld    = ref_primed;
            ref_prev   = d;
            ref_idx    = ref_idx + LANES;
            ref_primed = 1'b1;
        end else begin
            ref_vld = 1'b0;
        end
        @(negedge clk);
        check(frm_vld === ref_vld, {tag, " valid"}, NL*OW'(frm_vld), NL*OW'(ref_vld));
        check(frm_data === ref_data, {tag, " data"}, frm_data, ref_data);
    endtask

    function automatic logic [LANES*SW-1:0] rand_group();
        logic [LANES*SW-1:0] g;
        for (int j = 0; j < LANES; j++) g[j*SW +: SW] = SW'($urandom);
        return g;
    endfunction

    function automatic logic [LANES*SW-1:0] fill(input logic [SW-1:0] s);
        logic [LANES*SW-1:0] g;
        for (int j = 0; j < LANES; j++) g[j*SW +: SW] = s;
        return g;
    endfunction

    initial begin
        #(200000 * 20);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd7219));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(frm_vld === 1'b0, "R1 reset valid", NL*OW'(frm_vld), '0);
        check(frm_data === '0, "R1 reset data", frm_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(frm_vld === 1'b0 && frm_data === '0, "R1 after reset", frm_data, '0);

        // R2: first group gives no valid frame
        step(1'b1, rand_group(), "R2 first group");
        // R3/R4/R5: consecutive groups
        step(1'b1, rand_group(), "R3 second group");
        step(1'b1, rand_group(), "R4 overlap order");
        // R7: idle cycles are ignored
        step(1'b0, rand_group(), "R7 idle");
        step(1'b0, rand_group(), "R7 idle again");
        step(1'b1, rand_group(), "R7 resume after idle");
        // R6: widening corners
        step(1'b1, fill(8'h80), "R6 all -128");
        step(1'b1, fill(8'h80), "R6 all -128 repeat");
        step(1'b1, fill(8'h7F), "R6 all +127");
        step(1'b1, fill(8'h00), "R5 all zero");

        // random mix of groups and stalls
        for (int i = 0; i < 200; i++) begin
            if (($urandom % 4) == 0) step(1'b0, rand_group(), "R7 random idle");
            else                     step(1'b1, rand_group(), "R5 random frame");
        end

        // R2: re-reset, then first group suppressed again
        rst_n = 1'b0;
        smp_vld = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        ref_prev = '0; ref_idx = 0; ref_primed = 1'b0; ref_data = '0; ref_vld = 1'b0;
        check(frm_vld === 1'b0 && frm_data === '0, "R1 second reset", frm_data, '0);
        step(1'b1, rand_group(), "R2 first after re-reset");
        step(1'b1, rand_group(), "R3 second after re-reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule